// File: doc/BRIEF.md
# Train Speed Supervision Brake Controller

This block supervises the speed of a train against braking curves that depend on where the train is on the track. It takes an estimated position and speed, a mode command and a driver reset request. From these it drives three outputs: an emergency brake, a service brake and a driver warning.

All evaluation happens on a single-cycle control strobe, nominally once every 250 ms of system time. Between strobes the outputs hold their values.

The track is split into fixed-length segments. The segment index selects three speed limits from built-in curves: the maximum speed, the service-brake speed and the warning speed. The curves are computed from parameters when the block is elaborated.

Supervision applies only in the supervision mode. In standby the warning and service brake are forced low, but an emergency brake that is already latched stays applied. The emergency brake is latched. The warning follows the speed directly, and the service brake has hysteresis.

Top module: `speed_guard`

## Requirements
- R1: While rst_n is low at a clock edge, the block enters standby mode and all three outputs (emerg_brake, service_brake, warn) are low after that edge.
- R2: At a strobe with mode_set high, the mode becomes mode_sel (1 = supervision, 0 = standby), and that new mode already governs the evaluation at the same strobe. Without mode_set at a strobe, or with no strobe at all, the mode is kept.
- R3: Outputs change only at a clock edge where cycle_strobe is high. With the strobe low, any input change leaves all outputs unchanged.
- R4: The segment index is position >> SEG_SHIFT, clamped to NSEG-1. With the defaults (SEG_SHIFT=9, NSEG=6) this gives 512-unit segments, and every position of 2560 or more maps to segment 5.
- R5: For segment s the limits are vmax = V_TOP - s*V_STEP, vsvc = vmax - SVC_MARGIN and vwarn = vsvc - WARN_MARGIN. With the defaults (200, 20, 10, 10), segment 0 gives 200/190/180 and segment 5 gives 100/90/80.
- R6: At a strobe in supervision mode, a speed strictly greater than vmax sets emerg_brake. A speed equal to vmax does not.
- R7: Once set, emerg_brake stays high in both modes. It is cleared only at a strobe where reset_req is high and speed is zero. A reset request at nonzero speed has no effect.
- R8: At each strobe, warn becomes 1 exactly when the mode is supervision and speed >= vwarn.
- R9: At a strobe in supervision mode, service_brake is set when speed >= vsvc and cleared when speed < vwarn. For speeds in between it keeps its value.
- R10: At a strobe in standby mode, warn and service_brake become 0, and the emergency brake is never newly set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_strobe | input | 1 | One-cycle pulse marking a control-cycle evaluation |
| mode_set | input | 1 | Apply mode_sel at this strobe |
| mode_sel | input | 1 | Requested mode: 1 supervision, 0 standby |
| reset_req | input | 1 | Driver request to release the emergency brake |
| position | input | POS_W (12) | Estimated track position |
| speed | input | SPD_W (8) | Estimated train speed |
| emerg_brake | output | 1 | Latched emergency brake command |
| service_brake | output | 1 | Service brake command |
| warn | output | 1 | Driver overspeed warning |

## Verification
The assertions check the following on every cycle:
- outputs stay stable while there is no strobe;
- the mode holds unless it is commanded;
- the emergency brake stays set unless the standstill release is taken;
- the service brake never stands without the warning;
- both non-latched outputs are low whenever the mode is standby;
- the segment index stays within the table.

The bench sweeps positions and speeds through every segment, including the clamped range, with mixed mode commands and reset requests. It compares each strobe against an arithmetic model of the curves. Only these scenarios can show the exact limit values per segment, the strict-versus-inclusive threshold boundaries, the hysteresis band, and that a reset at nonzero speed is ignored.

// File: rtl/sg_pkg.sv
// Shared definitions for the speed supervision controller.
// Assumes: curve arithmetic is done on 32-bit integers at elaboration time.
package sg_pkg;

    typedef enum logic {
        MODE_STANDBY   = 1'b0,
        MODE_SUPERVISE = 1'b1
    } sg_mode_e;

    // Curve point for a segment: base minus per-segment drop minus a margin.
    function automatic int curve_point(input int base, input int drop,
                                       input int seg, input int margin);
        return base - seg * drop - margin;
    endfunction

endpackage

// File: rtl/sg_segment.sv
// Maps a track position to a braking-curve segment index.
// The segment length is a power of two (1 << SEG_SHIFT).
// Positions past the last segment are clamped to the final table entry.
module sg_segment #(
    parameter int POS_W     = 12,
    parameter int SEG_SHIFT = 9,
    parameter int NSEG      = 6,
    parameter int IDX_W     = 3
) (
    input  logic [POS_W-1:0] position,
    output logic [IDX_W-1:0] seg_idx
);

    localparam logic [POS_W-1:0] LAST_SEG = POS_W'(NSEG - 1);

    logic [POS_W-1:0] raw_seg;

    // Divide by the segment length, then clamp to the last entry.
    always_comb begin
        raw_seg = position >> SEG_SHIFT;
        if (raw_seg > LAST_SEG) begin
            seg_idx = IDX_W'(NSEG - 1);
        end else begin
            seg_idx = raw_seg[IDX_W-1:0];
        end
    end

    // R4
    always_comb begin
        seg_range_chk: assert (int'(seg_idx) < NSEG)
            else $error("segment index outside table");
    end

endmodule

// File: rtl/sg_curve.sv
// Braking-curve lookup tables: maximum, service and warning speeds per segment.
// The tables are generated from parameters.
// Assumes the parameters keep every entry within 0 .. 2**SPD_W-1.
module sg_curve #(
    parameter int NSEG        = 6,
    parameter int IDX_W       = 3,
    parameter int SPD_W       = 8,
    parameter int V_TOP       = 200,
    parameter int V_STEP      = 20,
    parameter int SVC_MARGIN  = 10,
    parameter int WARN_MARGIN = 10
) (
    input  logic [IDX_W-1:0] seg_idx,
    output logic [SPD_W-1:0] v_max,
    output logic [SPD_W-1:0] v_svc,
    output logic [SPD_W-1:0] v_warn
);
    import sg_pkg::*;

    logic [SPD_W-1:0] max_tab  [NSEG];
    logic [SPD_W-1:0] svc_tab  [NSEG];
    logic [SPD_W-1:0] warn_tab [NSEG];

    // One table row per segment, computed at elaboration.
    for (genvar g = 0; g < NSEG; g++) begin : g_row
        localparam int VM = curve_point(V_TOP, V_STEP, g, 0);
        localparam int VS = curve_point(V_TOP, V_STEP, g, SVC_MARGIN);
        localparam int VW = curve_point(V_TOP, V_STEP, g, SVC_MARGIN + WARN_MARGIN);
        assign max_tab[g]  = SPD_W'(VM);
        assign svc_tab[g]  = SPD_W'(VS);
        assign warn_tab[g] = SPD_W'(VW);
    end

    // Select the row of the current segment.
    always_comb begin
        v_max  = max_tab[seg_idx];
        v_svc  = svc_tab[seg_idx];
        v_warn = warn_tab[seg_idx];
    end

    // R5
    always_comb begin
        curve_order_chk: assert (v_warn <= v_svc && v_svc <= v_max)
            else $error("braking curves out of order");
    end

endmodule

// File: rtl/sg_mode.sv
// Holds the operating mode (standby or supervision).
// The mode is updated only at a control strobe that carries a mode command.
// The effective mode shows the commanded value during that strobe,
// so the evaluation at the same strobe already uses the new mode.
module sg_mode (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cycle_strobe,
    input  logic            mode_set,
    input  logic            mode_sel,
    output sg_pkg::sg_mode_e mode_q,
    output sg_pkg::sg_mode_e mode_eff
);
    import sg_pkg::*;

    logic take_cmd;

    // A command is taken only when it arrives together with a strobe.
    always_comb begin
        take_cmd = cycle_strobe && mode_set;
        mode_eff = take_cmd ? sg_mode_e'(mode_sel) : mode_q;
    end

    // Mode register; standby after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_STANDBY;
        end else if (take_cmd) begin
            mode_q <= sg_mode_e'(mode_sel);
        end
    end

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cycle_strobe && mode_set) |=> $stable(mode_q))
        else $error("mode changed without a command");

endmodule

// File: rtl/sg_supervise.sv
// Brake and warning decision logic, evaluated once per control strobe.
// The emergency brake is latched and released only by a reset request
// at zero speed. The warning follows the speed directly. The service
// brake sets at the service speed and clears below the warning speed.
// Assumes the curve inputs are ordered: v_warn <= v_svc <= v_max.
module sg_supervise #(
    parameter int SPD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_strobe,
    input  sg_pkg::sg_mode_e mode_eff,
    input  sg_pkg::sg_mode_e mode_q,
    input  logic             reset_req,
    input  logic [SPD_W-1:0] speed,
    input  logic [SPD_W-1:0] v_max,
    input  logic [SPD_W-1:0] v_svc,
    input  logic [SPD_W-1:0] v_warn,
    output logic             eb_q,
    output logic             sb_q,
    output logic             wn_q
);
    import sg_pkg::*;

    logic supervising;
    logic at_standstill;
    logic release_ok;
    logic overspeed;
    logic eb_d;
    logic sb_d;
    logic wn_d;

    // Conditions derived from the current inputs.
    always_comb begin
        supervising   = (mode_eff == MODE_SUPERVISE);
        at_standstill = (speed == '0);
        release_ok    = reset_req && at_standstill;
        overspeed     = speed > v_max;
    end

    // Emergency brake: released at standstill on request, otherwise latched.
    always_comb begin
        if (eb_q) begin
            eb_d = !release_ok;
        end else begin
            eb_d = supervising && overspeed;
        end
    end

    // Warning follows the speed directly; the service brake has hysteresis.
    always_comb begin
        wn_d = supervising && (speed >= v_warn);
        if (!supervising) begin
            sb_d = 1'b0;
        end else if (speed >= v_svc) begin
            sb_d = 1'b1;
        end else if (speed < v_warn) begin
            sb_d = 1'b0;
        end else begin
            sb_d = sb_q;
        end
    end

    // Output registers, loaded only at a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eb_q <= 1'b0;
            sb_q <= 1'b0;
            wn_q <= 1'b0;
        end else if (cycle_strobe) begin
            eb_q <= eb_d;
            sb_q <= sb_d;
            wn_q <= wn_d;
        end
    end

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_strobe |=> $stable({eb_q, sb_q, wn_q}))
        else $error("outputs moved without a strobe");

    // R7
    eb_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eb_q && !(cycle_strobe && reset_req && speed == '0)) |=> eb_q)
        else $error("emergency brake released without standstill reset");

    // R9
    sb_needs_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_q |-> wn_q)
        else $error("service brake without warning");

    // R10
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STANDBY) |-> (!sb_q && !wn_q))
        else $error("warning or service brake active in standby");

endmodule

// File: rtl/speed_guard.sv
// Train speed supervision brake controller (top level).
// Chain: position -> segment index -> curve limits -> brake decision.
// The mode register feeds the decision logic.
// Assumes cycle_strobe is a one-cycle pulse per control cycle.
module speed_guard #(
    parameter int POS_W       = 12,
    parameter int SPD_W       = 8,
    parameter int SEG_SHIFT   = 9,
    parameter int NSEG        = 6,
    parameter int V_TOP       = 200,
    parameter int V_STEP      = 20,
    parameter int SVC_MARGIN  = 10,
    parameter int WARN_MARGIN = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_strobe,
    input  logic             mode_set,
    input  logic             mode_sel,
    input  logic             reset_req,
    input  logic [POS_W-1:0] position,
    input  logic [SPD_W-1:0] speed,
    output logic             emerg_brake,
    output logic             service_brake,
    output logic             warn
);
    import sg_pkg::*;

    localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1;

    logic [IDX_W-1:0] seg_idx;
    logic [SPD_W-1:0] v_max;
    logic [SPD_W-1:0] v_svc;
    logic [SPD_W-1:0] v_warn;
    sg_mode_e         mode_q;
    sg_mode_e         mode_eff;

    sg_segment #(
        .POS_W(POS_W), .SEG_SHIFT(SEG_SHIFT), .NSEG(NSEG), .IDX_W(IDX_W)
    ) u_segment (
        .position(position),
        .seg_idx (seg_idx)
    );

    sg_curve #(
        .NSEG(NSEG), .IDX_W(IDX_W), .SPD_W(SPD_W), .V_TOP(V_TOP),
        .V_STEP(V_STEP), .SVC_MARGIN(SVC_MARGIN), .WARN_MARGIN(WARN_MARGIN)
    ) u_curve (
        .seg_idx(seg_idx),
        .v_max  (v_max),
        .v_svc  (v_svc),
        .v_warn (v_warn)
    );

    sg_mode u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_strobe(cycle_strobe),
        .mode_set    (mode_set),
        .mode_sel    (mode_sel),
        .mode_q      (mode_q),
        .mode_eff    (mode_eff)
    );

    sg_supervise #(
        .SPD_W(SPD_W)
    ) u_supervise (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_strobe(cycle_strobe),
        .mode_eff    (mode_eff),
        .mode_q      (mode_q),
        .reset_req   (reset_req),
        .speed       (speed),
        .v_max       (v_max),
        .v_svc       (v_svc),
        .v_warn      (v_warn),
        .eb_q        (emerg_brake),
        .sb_q        (service_brake),
        .wn_q        (warn)
    );

    // R6
    eb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_strobe && mode_eff == MODE_SUPERVISE && speed > v_max) |=> emerg_brake)
        else $error("overspeed did not apply the emergency brake");

endmodule

// File: tb/speed_guard_test.sv
// Self-checking bench for speed_guard.
// It sweeps position and speed with mixed mode commands and reset
// requests, and compares against an arithmetic model of the curves.
module speed_guard_test;

    localparam int POS_W = 12;
    localparam int SPD_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cycle_strobe = 1'b0;
    logic             mode_set = 1'b0;
    logic             mode_sel = 1'b0;
    logic             reset_req = 1'b0;
    logic [POS_W-1:0] position = '0;
    logic [SPD_W-1:0] speed = '0;
    logic             emerg_brake;
    logic             service_brake;
    logic             warn;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state.
    bit m_mode = 1'b0;
    bit m_eb   = 1'b0;
    bit m_sb   = 1'b0;
    bit m_wn   = 1'b0;

    always #4 clk = ~clk;

    speed_guard uut (
        .clk(clk), .rst_n(rst_n), .cycle_strobe(cycle_strobe),
        .mode_set(mode_set), .mode_sel(mode_sel), .reset_req(reset_req),
        .position(position), .speed(speed), .emerg_brake(emerg_brake),
        .service_brake(service_brake), .warn(warn)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b (pos %0d speed %0d)",
                     tag, got, exp, position, speed);
        end
    endtask

    function automatic int seg_of(input int pos);
        int s = pos / 512;
        return (s > 5) ? 5 : s;
    endfunction

    // Apply one strobe, update the model, then compare the outputs.
    task automatic step(input int pos, input int spd, input bit rr,
                        input bit mv, input bit mc, input string tag);
        int vmax;
        int vsvc;
        int vwrn;
        @(negedge clk);
        position     = POS_W'(pos);
        speed        = SPD_W'(spd);
        reset_req    = rr;
        mode_set     = mv;
        mode_sel     = mc;
        cycle_strobe = 1'b1;
        vmax = 200 - 20 * seg_of(pos);
        vsvc = vmax - 10;
        vwrn = vsvc - 10;
        if (mv) m_mode = mc;
        if (m_eb) m_eb = !(rr && spd == 0);
        else      m_eb = m_mode && (spd > vmax);
        m_wn = m_mode && (spd >= vwrn);
        if (!m_mode)          m_sb = 1'b0;
        else if (spd >= vsvc) m_sb = 1'b1;
        else if (spd < vwrn)  m_sb = 1'b0;
        @(negedge clk);
        cycle_strobe = 1'b0;
        mode_set     = 1'b0;
        reset_req    = 1'b0;
        check({tag, " emerg"},   emerg_brake,   m_eb);
        check({tag, " service"}, service_brake, m_sb);
        check({tag, " warn"},    warn,          m_wn);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, sampled while reset is held.
        check("R1 emerg", emerg_brake, 1'b0);
        check("R1 service", service_brake, 1'b0);
        check("R1 warn", warn, 1'b0);
        rst_n = 1'b1;

        // R10: standby at overspeed sets nothing.
        step(0, 255, 0, 0, 0, "R10 standby overspeed");

        // R2: entering supervision takes effect at the same strobe.
        step(0, 185, 0, 1, 1, "R2 enter supervision");

        // R5/R6: boundaries in segment 0 (200/190/180).
        step(0, 179, 0, 0, 0, "R8 below warn");
        step(0, 180, 0, 0, 0, "R8 at warn");
        step(0, 189, 0, 0, 0, "R9 band no set");
        step(0, 190, 0, 0, 0, "R9 at service");
        step(0, 185, 0, 0, 0, "R9 hold in band");
        step(0, 200, 0, 0, 0, "R6 at vmax no brake");
        step(0, 201, 0, 0, 0, "R6 over vmax");

        // R7: the latch holds and a reset at speed is ignored.
        step(0, 50, 1, 0, 0, "R7 reset at speed ignored");
        step(0, 0, 0, 0, 0, "R7 standstill no request");
        step(0, 0, 1, 0, 0, "R7 release at standstill");

        // R4/R5: clamped segment 5 (100/90/80) beyond the table.
        step(4000, 101, 0, 0, 0, "R4 clamp over vmax");
        step(4000, 0, 1, 0, 0, "R7 release again");
        step(2600, 80, 0, 0, 0, "R4 clamp warn");

        // R3: input changes without a strobe leave the outputs unchanged.
        @(negedge clk);
        speed = 8'd250;
        reset_req = 1'b1;
        mode_set = 1'b1;
        mode_sel = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 emerg hold", emerg_brake, m_eb);
        check("R3 service hold", service_brake, m_sb);
        check("R3 warn hold", warn, m_wn);
        reset_req = 1'b0;
        mode_set = 1'b0;

        // R10: an emergency brake latched before standby stays applied.
        step(0, 210, 0, 0, 0, "R6 apply before standby");
        step(0, 150, 0, 1, 0, "R10 standby keeps latch");
        step(0, 0, 1, 0, 0, "R7 release in standby");

        // Sweep across all segments with mixed commands.
        for (int k = 0; k < 1600; k++) begin
            int pos = (k * 97) % 4096;
            int spd = (k % 6 == 0) ? 0 : (k * 37 + k / 7) % 256;
            bit rr  = (k % 5 == 0);
            bit mv  = (k % 13 == 0);
            bit mc  = ((k / 13) % 4) != 0;
            step(pos, spd, rr, mv, mc, "R4-sweep R5 R6 R8 R9");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule